// File: doc/BRIEF.md
# Machine Status Word Unit

This block keeps the 16-bit machine status word of a processor core and executes the two instructions that touch it: a store, which hands the word out, and a load, which writes a new word. A 2-bit generation select picks which core family the unit behaves as. On older generations a store pads the unused high bits with ones, and a load only takes some of its bits from the supplied value.

A load is privileged once protection is on. If bit 0 (protection enable) is set and the caller runs above privilege level 0 or in virtual mode, the load is refused. The block then pulses a fault and keeps the word unchanged. A load can never turn protection off again. A separate protected-mode output mirrors bit 0 for the rest of the core.

A request is a one-cycle `start_i` pulse with `op_load_i` selecting the operation. A load completes in the cycle after the start edge. A store takes two cycles and returns the padded word on `store_val_o`.

Top module: `msw_unit`

## Requirements
- R1: After reset the word, the stored value and the protected-mode flag are all zero, and neither `done_o` nor `fault_o` is high.
- R2: A store returns the word ORed with 0xFFF0 when `gen_i`=0 (oldest generation), ORed with 0xFF00 when `gen_i`=1 (middle generation), and unchanged when `gen_i` is 2 or 3 (newest generation).
- R3: A store accepted at clock edge k raises `done_o` for one cycle, with `store_val_o` valid, after edge k+1. A load accepted at edge k raises `done_o` or `fault_o` for one cycle after edge k.
- R4: A load faults when word bit 0 is 1 and either `cpl_i` is nonzero or `vm_i` is 1. A fault pulses `fault_o` instead of `done_o` and leaves the word unchanged.
- R5: A completed load never clears bit 0: if bit 0 was 1, the new word has bit 0 set whatever the load value.
- R6: For `gen_i` of 1 or above, bit 4 of the new word keeps its old value and ignores the load value.
- R7: For `gen_i`=0, only bits 3:0 of the load value are taken and bits 15:4 of the new word are zero.
- R8: `pmode_o` equals bit 0 of the word after every completed load.
- R9: A `start_i` arriving while a store is still in flight is ignored. It changes neither the word nor the store result.
- R10: `done_o` and `fault_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request pulse |
| op_load_i | input | 1 | 1 = load the word, 0 = store it |
| load_val_i | input | 16 | Value offered by a load |
| cpl_i | input | 2 | Current privilege level |
| vm_i | input | 1 | Virtual mode active |
| gen_i | input | 2 | Generation: 0 oldest, 1 middle, 2 or 3 newest |
| store_val_o | output | 16 | Result of the last store |
| word_o | output | 16 | Current status word |
| pmode_o | output | 1 | Protected-mode indication |
| fault_o | output | 1 | Refused-load pulse |
| done_o | output | 1 | Completion pulse |

## Verification
The bench builds the unit with its defaults: a 16-bit word and a two-cycle store. This makes the exact store completion cycle, and the window in which a second start must be dropped, observable at the ports. Since bit 4 can only start at zero, R6 is exercised through load values with bit 4 set that must not reach the word. Bit 0 is forced on through a load on the oldest generation, which opens up the fault cases and the sticky protection bit.

// File: rtl/msw_pkg.sv
package msw_pkg;
  typedef enum logic [1:0] {
    GEN_OLD = 2'd0,
    GEN_MID = 2'd1,
    GEN_NEW = 2'd2,
    GEN_NEW_ALT = 2'd3
  } gen_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_STORE = 1'b1
  } state_e;
endpackage

// File: rtl/msw_rst_sync.sv
module msw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/msw_store_fmt.sv
module msw_store_fmt
  import msw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] word_i,
  input  gen_e         gen_i,
  output logic [W-1:0] fmt_o
);
  localparam logic [W-1:0] PAD_OLD = ~W'(16'h000F);
  localparam logic [W-1:0] PAD_MID = ~W'(16'h00FF);

  always_comb begin
    unique case (gen_i)
      GEN_OLD: fmt_o = word_i | PAD_OLD;
      GEN_MID: fmt_o = word_i | PAD_MID;
      default: fmt_o = word_i;
    endcase
  end
endmodule

// File: rtl/msw_load_merge.sv
module msw_load_merge
  import msw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] val_i,
  input  gen_e         gen_i,
  input  logic [1:0]   cpl_i,
  input  logic         vm_i,
  output logic         deny_o,
  output logic [W-1:0] new_o
);
  localparam int PE_BIT  = 0;
  localparam int ET_BIT  = 4;
  localparam int OLD_KEEP = 4;

  logic [W-1:0] with_pe;

  always_comb begin
    deny_o  = old_i[PE_BIT] && ((cpl_i != 2'd0) || vm_i);
    with_pe = val_i;
    with_pe[PE_BIT] = val_i[PE_BIT] | old_i[PE_BIT];
    if (gen_i == GEN_OLD) begin
      new_o = '0;
      new_o[OLD_KEEP-1:0] = with_pe[OLD_KEEP-1:0];
    end else begin
      new_o = with_pe;
      new_o[ET_BIT] = old_i[ET_BIT];
    end
  end
endmodule

// File: rtl/msw_unit.sv
module msw_unit
  import msw_pkg::*;
#(
  parameter int W         = 16,
  parameter int STORE_LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         op_load_i,
  input  logic [15:0]  load_val_i,
  input  logic [1:0]   cpl_i,
  input  logic         vm_i,
  input  logic [1:0]   gen_i,
  output logic [15:0]  store_val_o,
  output logic [15:0]  word_o,
  output logic         pmode_o,
  output logic         fault_o,
  output logic         done_o
);
  localparam int CW = $clog2(STORE_LAT + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(STORE_LAT - 1);

  logic rst_s_n;

  state_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  gen_e          gen_q, gen_d;
  logic [W-1:0]  word_q, word_d;
  logic [W-1:0]  store_q, store_d;
  logic          pmode_q, pmode_d;
  logic          done_q, done_d;
  logic          fault_q, fault_d;
  logic          was_load_q, was_load_d;
  logic          word_en, store_en;

  logic          deny;
  logic [W-1:0]  merged;
  logic [W-1:0]  fmt;
  logic          accept;

  msw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  msw_load_merge #(.W(W)) u_merge (
    .old_i  (word_q),
    .val_i  (W'(load_val_i)),
    .gen_i  (gen_e'(gen_i)),
    .cpl_i  (cpl_i),
    .vm_i   (vm_i),
    .deny_o (deny),
    .new_o  (merged)
  );

  msw_store_fmt #(.W(W)) u_fmt (
    .word_i (word_q),
    .gen_i  (gen_q),
    .fmt_o  (fmt)
  );

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    gen_d      = gen_q;
    word_d     = word_q;
    store_d    = store_q;
    pmode_d    = pmode_q;
    was_load_d = was_load_q;
    done_d     = 1'b0;
    fault_d    = 1'b0;
    word_en    = 1'b0;
    store_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          was_load_d = op_load_i;
          if (op_load_i) begin
            if (deny) begin
              fault_d = 1'b1;
            end else begin
              word_en = 1'b1;
              word_d  = merged;
              pmode_d = merged[0];
              done_d  = 1'b1;
            end
          end else begin
            gen_d   = gen_e'(gen_i);
            cnt_d   = CNT_INIT;
            state_d = ST_STORE;
          end
        end
      end
      ST_STORE: begin
        if (cnt_q <= CW'(1)) begin
          store_en = 1'b1;
          store_d  = fmt;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      gen_q      <= GEN_NEW;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      was_load_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      gen_q      <= gen_d;
      done_q     <= done_d;
      fault_q    <= fault_d;
      was_load_q <= was_load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      word_q  <= '0;
      pmode_q <= 1'b0;
    end else if (word_en) begin
      word_q  <= word_d;
      pmode_q <= pmode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      store_q <= '0;
    else if (store_en) store_q <= store_d;
  end

  assign store_val_o = 16'(store_q);
  assign word_o      = 16'(word_q);
  assign pmode_o     = pmode_q;
  assign fault_o     = fault_q;
  assign done_o      = done_q;

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(done_q && fault_q)); // R10
  AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    word_q[0] |=> word_q[0]); // R5
  AST_FAULT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_s_n)
    start_i && op_load_i && state_q == ST_IDLE && deny |=> fault_q && $stable(word_q)); // R4
  AST_PMODE_TRACKS: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_q && was_load_q |-> pmode_q == word_q[0]); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_s_n)
    state_q == ST_STORE |=> $stable(word_q)); // R9
  AST_OLD_GEN_LOAD: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept && op_load_i && !deny && gen_i == 2'd0 |=> word_q[W-1:4] == '0); // R7
endmodule

// File: tb/sim_msw_unit.sv
module sim_msw_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, op_load_i, vm_i;
  logic [15:0] load_val_i;
  logic [1:0]  cpl_i, gen_i;
  logic [15:0] store_val_o, word_o;
  logic        pmode_o, fault_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msw_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_load_i(op_load_i),
    .load_val_i(load_val_i), .cpl_i(cpl_i), .vm_i(vm_i), .gen_i(gen_i),
    .store_val_o(store_val_o), .word_o(word_o), .pmode_o(pmode_o),
    .fault_o(fault_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive a load; sample after the accepting edge.
  task automatic do_load(input logic [15:0] v, input logic [1:0] g,
                         input logic [1:0] c, input logic vm,
                         input logic exp_fault, input logic [15:0] exp_word);
    @(negedge clk);
    start_i = 1; op_load_i = 1; load_val_i = v; gen_i = g; cpl_i = c; vm_i = vm;
    @(negedge clk);
    start_i = 0;
    chk("R3 load done",  {15'd0, done_o},  {15'd0, !exp_fault});
    chk("R4 fault",      {15'd0, fault_o}, {15'd0, exp_fault});
    chk("R10 exclusive", {15'd0, done_o & fault_o}, 16'd0);
    chk("R5/R6/R7 word", word_o, exp_word);
    chk("R8 pmode",      {15'd0, pmode_o}, {15'd0, exp_word[0]});
    @(negedge clk);
    chk("R3 single pulse", {14'd0, done_o, fault_o}, 16'd0);
  endtask

  task automatic do_store(input logic [1:0] g, input logic [15:0] exp_val,
                          input logic poke);
    logic [15:0] w_before;
    w_before = word_o;
    @(negedge clk);
    start_i = 1; op_load_i = 0; gen_i = g;
    @(negedge clk);
    chk("R3 store not early", {15'd0, done_o}, 16'd0);
    if (poke) begin
      start_i = 1; op_load_i = 1; load_val_i = 16'hFFFF; cpl_i = 0; vm_i = 0; gen_i = 2'd2;
    end else begin
      start_i = 0;
    end
    @(negedge clk);
    start_i = 0;
    chk("R3 store done", {15'd0, done_o}, 16'd1);
    chk("R2 store value", store_val_o, exp_val);
    if (poke) chk("R9 busy start ignored", word_o, w_before);
    @(negedge clk);
    chk("R3 store single pulse", {14'd0, done_o, fault_o}, 16'd0);
    if (poke) chk("R9 no late effect", word_o, w_before);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; op_load_i = 0; load_val_i = 0;
    cpl_i = 0; vm_i = 0; gen_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 word", word_o, 16'h0000);
    chk("R1 store", store_val_o, 16'h0000);
    chk("R1 flags", {13'd0, pmode_o, done_o, fault_o}, 16'd0);

    // R2 store padding per generation, word 0
    do_store(2'd0, 16'hFFF0, 0);
    do_store(2'd1, 16'hFF00, 0);
    do_store(2'd2, 16'h0000, 0);

    // R6 bit 4 kept from old on middle/new generations
    do_load(16'h12F6, 2'd1, 2'd3, 1'b1, 1'b0, 16'h12E6);
    do_store(2'd3, 16'h12E6, 0);
    do_store(2'd1, 16'hFFE6, 0);
    do_load(16'h0010, 2'd2, 2'd0, 1'b0, 1'b0, 16'h0000);

    // R7 oldest generation keeps low nibble only
    do_load(16'hFFFE, 2'd0, 2'd0, 1'b0, 1'b0, 16'h000E);
    // R5 sets PE, then cannot clear it
    do_load(16'h0001, 2'd0, 2'd0, 1'b0, 1'b0, 16'h0001);
    do_load(16'h0000, 2'd2, 2'd0, 1'b0, 1'b0, 16'h0001);

    // R4 faults: privilege and virtual mode
    do_load(16'hFFFF, 2'd1, 2'd1, 1'b0, 1'b1, 16'h0001);
    do_load(16'hFFFF, 2'd2, 2'd0, 1'b1, 1'b1, 16'h0001);
    do_load(16'hFFFF, 2'd0, 2'd3, 1'b1, 1'b1, 16'h0001);

    // R9 start during store is dropped
    do_store(2'd0, 16'hFFF1, 1);
    do_store(2'd2, 16'h0001, 0);

    // middle-generation load with PE set, privilege 0
    do_load(16'hFFF0, 2'd1, 2'd0, 1'b0, 1'b0, 16'hFFE1);
    do_store(2'd0, 16'hFFF1, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule